// File: doc/BRIEF.md
# Speculative Store Buffer

This block keeps the stores that a processor makes while it runs a speculative block of work. Those stores stay private to the processor until the block commits. It is a small, fully associative set of slots, each holding an address and a data word. The processor's own loads probe it first. On a hit, the slot's data wins over whatever the dependency cache holds for the same address. Other processors on the shared bus see none of these stores while the block is still speculative.

A single clear pulse empties the buffer. The processor raises it when a block starts or when a block is aborted. When the block reaches the head of the commit order, a commit-start pulse begins a sweep. The sweep drives every held store onto the shared memory bus, one at a time, with a valid/ready handshake. When the last store has been accepted, the buffer is empty and a one-cycle commit-done pulse is raised. Slots are taken lowest-free-first and are never freed on their own. So the sweep order is the order in which each address was first written during the block.

Top module: `spec_wbuf`

## Requirements
- R1: After reset the buffer is empty: `full`, `rd_hit`, `bus_valid` and `commit_done` are all low.
- R2: A store accepted in one cycle (`wr_valid` and `wr_ready` both high at a rising edge) is returned by the read lookup from the next cycle on: `rd_hit` is 1 and `rd_data` is the stored word.
- R3: A lookup of an address that no slot holds gives `rd_hit` = 0 and `rd_data` = 0.
- R4: A store to an address already held overwrites that slot's data in place and takes no extra slot.
- R5: `full` is high exactly when all DEPTH slots hold distinct addresses. While full, a store to a new address sees `wr_ready` = 0 and is not kept. A store to an address already held is still accepted.
- R6: A `clr` pulse empties every slot. From the next cycle, every lookup misses and `full` is low. A store in the same cycle as `clr` is refused.
- R7: Outside a commit sweep, `bus_valid` stays low, so no held store reaches the bus.
- R8: After `commit_start`, the buffer drives one bus write per held address, in order of each address's first store, carrying its latest data. `bus_addr` and `bus_data` are held steady while `bus_ready` is low.
- R9: `commit_done` is high for exactly one cycle: the cycle after the last bus write is accepted, or the cycle after `commit_start` if the buffer is empty. The buffer is empty afterwards.
- R10: During a commit sweep `wr_ready` is low.
- R11: A `clr` during a sweep cancels it. From the next cycle `bus_valid` is low, no `commit_done` is raised, and the remaining stores are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Block start or abort: empty the buffer |
| wr_valid | input | 1 | Processor store request |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| wr_ready | output | 1 | Store accepted this cycle |
| full | output | 1 | All slots in use |
| rd_addr | input | AW | Lookup address |
| rd_hit | output | 1 | Lookup address is held |
| rd_data | output | DW | Held data on a hit, zero otherwise |
| commit_start | input | 1 | Begin the commit sweep |
| commit_done | output | 1 | One-cycle pulse: sweep finished |
| bus_valid | output | 1 | Bus write request |
| bus_addr | output | AW | Bus write address |
| bus_data | output | DW | Bus write data |
| bus_ready | input | 1 | Bus accepts the write |

## Verification
Stores are tried with three patterns: fresh addresses, repeats of a held address, and fresh addresses against a full buffer. These separate allocation from in-place merge from stalling, and the check is on which words come back from the lookup. Commits are run with a bus that accepts every cycle and with one that stalls on alternate cycles. Comparing the two shows whether the order and data hold and whether the drive stays stable under back-pressure. A commit of an empty buffer and a clear in mid-sweep check the done pulse at its two edges.

// File: rtl/swb_pkg.sv
package swb_pkg;

  localparam int MAX_SLOTS = 64;

  typedef enum logic { SW_IDLE, SW_FLUSH } sweep_state_e;

  // Lowest set bit position of a vector; 0 when the vector is empty.
  function automatic int lowest_set(input logic [MAX_SLOTS-1:0] v);
    for (int i = 0; i < MAX_SLOTS; i++) begin
      if (v[i]) return i;
    end
    return 0;
  endfunction

endpackage

// File: rtl/swb_store.sv
module swb_store #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int DEPTH = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic             wr_match,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_hit,
  output logic [DW-1:0]    rd_data,
  output logic [DEPTH-1:0] valid_o,
  input  logic [IW-1:0]    sel_idx,
  input  logic             inval_en,
  output logic [AW-1:0]    sel_addr,
  output logic [DW-1:0]    sel_data
);

  logic [AW-1:0]    slot_addr [DEPTH];
  logic [DW-1:0]    slot_data [DEPTH];
  logic [DEPTH-1:0] slot_vld;
  logic [DEPTH-1:0] hit_wr, hit_rd;
  logic [swb_pkg::MAX_SLOTS-1:0] ext_hit, ext_free;
  logic [IW-1:0]    wr_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign hit_wr[g] = slot_vld[g] && (slot_addr[g] == wr_addr);
    assign hit_rd[g] = slot_vld[g] && (slot_addr[g] == rd_addr);
  end

  always_comb begin
    ext_hit = '0;
    ext_free = '0;
    ext_hit[DEPTH-1:0] = hit_wr;
    ext_free[DEPTH-1:0] = ~slot_vld;
  end

  // Merge into the matching slot, otherwise take the lowest free one.
  assign wr_match = |hit_wr;
  assign wr_idx = wr_match ? IW'(swb_pkg::lowest_set(ext_hit))
                           : IW'(swb_pkg::lowest_set(ext_free));

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_rd[i]) rd_data = rd_data | slot_data[i];
    end
  end
  assign rd_hit = |hit_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld <= '0;
    end else if (clr) begin
      slot_vld <= '0;
    end else begin
      if (wr_en) slot_vld[wr_idx] <= 1'b1;
      if (inval_en) slot_vld[sel_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) begin
      slot_addr[wr_idx] <= wr_addr;
      slot_data[wr_idx] <= wr_data;
    end
  end

  assign valid_o  = slot_vld;
  assign sel_addr = slot_addr[sel_idx];
  assign sel_data = slot_data[sel_idx];

endmodule

// File: rtl/swb_sweep.sv
module swb_sweep #(
  parameter int DEPTH = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             commit_start,
  input  logic [DEPTH-1:0] valid_i,
  input  logic             bus_ready,
  output logic             sweeping,
  output logic             bus_valid,
  output logic [IW-1:0]    sel_idx,
  output logic             flush_accept,
  output logic             commit_done
);

  swb_pkg::sweep_state_e state_q, state_d;
  logic [swb_pkg::MAX_SLOTS-1:0] ext_vld;
  logic any_vld;

  always_comb begin
    ext_vld = '0;
    ext_vld[DEPTH-1:0] = valid_i;
  end

  assign any_vld      = |valid_i;
  assign sweeping     = (state_q == swb_pkg::SW_FLUSH);
  assign sel_idx      = IW'(swb_pkg::lowest_set(ext_vld));
  assign bus_valid    = sweeping && any_vld;
  assign flush_accept = bus_valid && bus_ready && !clr;
  assign commit_done  = sweeping && !any_vld;

  always_comb begin
    state_d = state_q;
    if (clr) state_d = swb_pkg::SW_IDLE;
    else if (!sweeping && commit_start) state_d = swb_pkg::SW_FLUSH;
    else if (commit_done) state_d = swb_pkg::SW_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= swb_pkg::SW_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/spec_wbuf.sv
module spec_wbuf #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          full,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hit,
  output logic [DW-1:0] rd_data,
  input  logic          commit_start,
  output logic          commit_done,
  output logic          bus_valid,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  input  logic          bus_ready
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] valid_vec;
  logic [IW-1:0]    sel_idx;
  logic             wr_match, wr_accept, flush_accept, sweeping;

  assign full      = &valid_vec;
  assign wr_ready  = !clr && !sweeping && (wr_match || !full);
  assign wr_accept = wr_valid && wr_ready;

  swb_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(wr_accept), .wr_addr(wr_addr), .wr_data(wr_data), .wr_match(wr_match),
    .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
    .valid_o(valid_vec), .sel_idx(sel_idx), .inval_en(flush_accept),
    .sel_addr(bus_addr), .sel_data(bus_data)
  );

  swb_sweep #(.DEPTH(DEPTH)) u_sweep (
    .clk(clk), .rst_n(rst_n), .clr(clr), .commit_start(commit_start),
    .valid_i(valid_vec), .bus_ready(bus_ready), .sweeping(sweeping),
    .bus_valid(bus_valid), .sel_idx(sel_idx), .flush_accept(flush_accept),
    .commit_done(commit_done)
  );

endmodule

// File: rtl/swb_checker.sv
module swb_checker #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             wr_match,
  input logic             full,
  input logic             sweeping,
  input logic             bus_valid,
  input logic             bus_ready,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_data,
  input logic             commit_done,
  input logic [DEPTH-1:0] valid_vec
);

  p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_valid && !wr_match |-> !wr_ready);

  p_clear_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid_vec == '0));

  p_private_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sweeping |-> !bus_valid);

  p_bus_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready && !clr |=> bus_valid && $stable(bus_addr) && $stable(bus_data));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> !commit_done && !sweeping);

  p_sweep_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sweeping |-> !wr_ready);

  p_clear_cancel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !bus_valid && !commit_done);

endmodule

bind spec_wbuf swb_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_swb_checker (
  .clk(clk), .rst_n(rst_n), .clr(clr), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_match(wr_match), .full(full), .sweeping(sweeping), .bus_valid(bus_valid),
  .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_data(bus_data),
  .commit_done(commit_done), .valid_vec(valid_vec)
);

// File: tb/test_spec_wbuf.sv
module test_spec_wbuf;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, clr = 1'b0, wr_valid = 1'b0, commit_start = 1'b0, bus_ready = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, full, rd_hit, commit_done, bus_valid;
  logic [DW-1:0] rd_data, bus_data;
  logic [AW-1:0] bus_addr;

  spec_wbuf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_spec_wbuf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready), .full(full), .rd_addr(rd_addr),
    .rd_hit(rd_hit), .rd_data(rd_data), .commit_start(commit_start),
    .commit_done(commit_done), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_ready(bus_ready)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [AW-1:0] m_addr [DEPTH];
  logic [DW-1:0] m_data [DEPTH];
  int m_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int m_find(input logic [AW-1:0] a);
    for (int i = 0; i < m_cnt; i++) if (m_addr[i] == a) return i;
    return -1;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    int f;
    bit ok;
    f = m_find(a);
    ok = (f >= 0) || (m_cnt < DEPTH);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #1;
    chk(wr_ready == ok, req, wr_ready, ok);
    @(negedge clk);
    wr_valid = 1'b0;
    if (ok) begin
      if (f >= 0) m_data[f] = d;
      else begin m_addr[m_cnt] = a; m_data[m_cnt] = d; m_cnt++; end
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit hit, input logic [DW-1:0] d, input string req);
    rd_addr = a;
    #1;
    chk(rd_hit == hit, req, rd_hit, hit);
    chk(rd_data == (hit ? d : '0), req, rd_data, hit ? d : '0);
  endtask

  task automatic rd_all_model(input string req);
    for (int i = 0; i < m_cnt; i++) rd(m_addr[i], 1'b1, m_data[i], req);
  endtask

  task automatic clear_all();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    m_cnt = 0;
  endtask

  // Commit sweep; stall=1 makes the bus refuse every other cycle.
  task automatic commit(input bit stall, input string req);
    int k;
    int n;
    logic [AW-1:0] old_addr [DEPTH];
    k = 0;
    n = m_cnt;
    for (int i = 0; i < m_cnt; i++) old_addr[i] = m_addr[i];
    @(negedge clk); commit_start = 1'b1;
    @(negedge clk); commit_start = 1'b0;
    for (int cyc = 0; cyc < 64; cyc++) begin
      #1;
      if (cyc == 0) begin
        wr_valid = 1'b1; wr_addr = 16'hFFFF; wr_data = 32'h1;
        #1;
        chk(wr_ready == 1'b0, "R10 store refused during sweep", wr_ready, 0);
      end
      if (k < n) begin
        chk(bus_valid == 1'b1, {req, " R8 bus_valid"}, bus_valid, 1);
        chk(bus_addr == m_addr[k], {req, " R8 order"}, bus_addr, m_addr[k]);
        chk(bus_data == m_data[k], {req, " R8 data"}, bus_data, m_data[k]);
        chk(commit_done == 1'b0, {req, " R9 early done"}, commit_done, 0);
        bus_ready = stall ? (cyc % 2 == 1) : 1'b1;
      end else begin
        chk(commit_done == 1'b1, {req, " R9 done"}, commit_done, 1);
        chk(bus_valid == 1'b0, {req, " R8 bus idle at done"}, bus_valid, 0);
        bus_ready = 1'b0;
        wr_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(commit_done == 1'b0, {req, " R9 single pulse"}, commit_done, 0);
        break;
      end
      @(negedge clk);
      wr_valid = 1'b0;
      if (bus_ready) k++;
      bus_ready = 1'b0;
    end
    m_cnt = 0;
    for (int i = 0; i < n; i++) rd(old_addr[i], 1'b0, '0, {req, " R9 empty after"});
  endtask

  task automatic t_reset();
    #1;
    chk(full == 1'b0, "R1 full", full, 0);
    chk(bus_valid == 1'b0, "R1 bus_valid", bus_valid, 0);
    chk(commit_done == 1'b0, "R1 commit_done", commit_done, 0);
    rd(16'h0000, 1'b0, '0, "R1 lookup");
  endtask

  task automatic t_write_read();
    wr(16'h0100, 32'hAAAA0001, "R2 store");
    wr(16'h0204, 32'hBBBB0002, "R2 store");
    rd_all_model("R2 lookup");
    rd(16'h0300, 1'b0, '0, "R3 miss");
    chk(bus_valid == 1'b0, "R7 private", bus_valid, 0);
    clear_all();
  endtask

  task automatic t_overwrite();
    wr(16'h0010, 32'h11111111, "R4 first");
    wr(16'h0010, 32'h22222222, "R4 merge");
    rd(16'h0010, 1'b1, 32'h22222222, "R4 latest data");
    wr(16'h0020, 32'h3, "R4 fill");
    wr(16'h0030, 32'h4, "R4 fill");
    #1;
    chk(full == 1'b0, "R4 merge used no slot", full, 0);
    wr(16'h0040, 32'h5, "R4 fill last");
    #1;
    chk(full == 1'b1, "R5 full", full, 1);
    chk(bus_valid == 1'b0, "R7 private when full", bus_valid, 0);
  endtask

  task automatic t_full();
    wr(16'h0050, 32'h6, "R5 new refused");
    rd(16'h0050, 1'b0, '0, "R5 refused not kept");
    wr(16'h0020, 32'h77777777, "R5 merge while full");
    rd_all_model("R5 contents");
  endtask

  task automatic t_clear();
    @(negedge clk);
    clr = 1'b1; wr_valid = 1'b1; wr_addr = 16'h0999; wr_data = 32'h9;
    #1;
    chk(wr_ready == 1'b0, "R6 store refused with clr", wr_ready, 0);
    @(negedge clk);
    clr = 1'b0; wr_valid = 1'b0;
    #1;
    chk(full == 1'b0, "R6 full dropped", full, 0);
    for (int i = 0; i < m_cnt; i++) rd(m_addr[i], 1'b0, '0, "R6 emptied");
    rd(16'h0999, 1'b0, '0, "R6 clr-cycle store dropped");
    m_cnt = 0;
  endtask

  task automatic t_clear_commit();
    wr(16'h0A00, 32'hA0, "R11 setup");
    wr(16'h0B00, 32'hB0, "R11 setup");
    wr(16'h0C00, 32'hC0, "R11 setup");
    @(negedge clk); commit_start = 1'b1;
    @(negedge clk); commit_start = 1'b0; bus_ready = 1'b1;
    #1;
    chk(bus_addr == 16'h0A00, "R11 first write driven", bus_addr, 16'h0A00);
    @(negedge clk); bus_ready = 1'b0; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    #1;
    chk(bus_valid == 1'b0, "R11 sweep cancelled", bus_valid, 0);
    chk(commit_done == 1'b0, "R11 no done", commit_done, 0);
    rd(16'h0B00, 1'b0, '0, "R11 discarded");
    rd(16'h0C00, 1'b0, '0, "R11 discarded");
    @(negedge clk);
    #1;
    chk(commit_done == 1'b0, "R11 no late done", commit_done, 0);
    m_cnt = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #35;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_write_read();
    t_overwrite();
    t_full();
    commit(1'b0, "full commit");
    wr(16'h0300, 32'hC1, "R2 store");
    wr(16'h0100, 32'hC2, "R2 store");
    wr(16'h0300, 32'hC3, "R4 merge");
    wr(16'h0200, 32'hC4, "R2 store");
    commit(1'b1, "stalled commit");
    commit(1'b0, "empty commit");
    wr(16'h0111, 32'h1, "R6 setup");
    wr(16'h0222, 32'h2, "R6 setup");
    t_clear();
    t_clear_commit();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule